// File: doc/BRIEF.md
# Error Counter Bank with Overflow Interrupts

This block holds a set of independent 12-bit event counters. Each counter is advanced by a one-cycle pulse from the error detection logic around it. Each counter has an interrupt-enable bit, and that bit also selects how the counter overflows. With the bit set, the counter rolls from its top value back to zero, latches an overflow flag and keeps counting. With the bit clear, the counter stops at its top value and stays there until software clears it.

A single status word collects the overflow flags and two kinds of per-port event flags: one for a fully received cell and one for a cell sent from a source. An enable word with the same bit layout masks these flags onto one interrupt line. Software reaches the block through a plain read/write strobe interface. Reading the status word returns the flags and clears them. Writing a counter address zeroes that counter. Reading a counter address leaves the count as it is.

Top module: `ecb_bank`

## Requirements
- R1: After reset, every counter, the enable word and the status word are zero, and `irq_o` is low.
- R2: Each pulse on `cnt_inc_i[k]` raises counter k by one at the next clock edge. Counters do not affect one another.
- R3: When enable bit k is 0, counter k stops at 0xFFF and holds there under further pulses. Overflow status bit k is not set.
- R4: When enable bit k is 1 and counter k is at 0xFFF, the next pulse wraps the counter to 0 and sets status bit k. Later pulses count on from 0.
- R5: A pulse on `rx_evt_i[p]` sets status bit NUM_CNT+p. A pulse on `tx_evt_i[p]` sets status bit NUM_CNT+NUM_PORT+p. With the default parameters these are bits 4..5 and 6..7, and bits 0..3 are the counter overflows.
- R6: A read strobe at the status address returns the status word in the same cycle and clears every status bit at the following clock edge.
- R7: An event that arrives in the same cycle as a status read is still set in the status word after the read.
- R8: `irq_o` is high exactly when some status bit is set and its enable bit is also set.
- R9: A write strobe at the address of counter k zeroes that counter, even if an increment pulse arrives in the same cycle. A read of a counter returns its value and does not change it.
- R10: The address map is: 0 is the enable word (read/write), 1 is the status word (writes are ignored), and 2+k is counter k. Reads from unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_inc_i | input | NUM_CNT | One-cycle increment pulse for each counter |
| rx_evt_i | input | NUM_PORT | Per-port cell-received event pulse |
| tx_evt_i | input | NUM_PORT | Per-port cell-sent event pulse |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | STAT_W | Write data (used by the enable word) |
| rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench drives a disabled counter past 0xFFF and expects it to hold there. A design that wraps anyway would read back a small value. It also drives an enabled counter across the boundary and expects 0, then a running count, plus a status bit. A missing wrap or a lost flag shows up on both reads. It issues a status read in the same cycle as an event and expects the event in the next read, which catches a clear that takes priority over a set. Further checks cover a counter clear that coincides with an increment, a write to the read-only status word, unmapped reads, and an event flag with its enable off that must not raise `irq_o`.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
    localparam int unsigned ADDR_EN   = 0;
    localparam int unsigned ADDR_STAT = 1;
    localparam int unsigned ADDR_CNT0 = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EN,
        SEL_STAT,
        SEL_CNT
    } rsel_e;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             wrap_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_max;

    always_comb begin
        st_d   = st_q;
        ovf_o  = 1'b0;
        at_max = (st_q.cnt == CNT_MAX);
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            if (!at_max) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (wrap_en_i) begin
                st_d.cnt = '0;
                ovf_o    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/ecb_status.sv
module ecb_status #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_we_i,
    input  logic [STAT_W-1:0] en_wdata_i,
    input  logic              rd_clr_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] en_o,
    output logic [STAT_W-1:0] stat_o
);
    typedef struct packed {
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] stat;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) st_d.en = en_wdata_i;
        // A new event always survives a clear in the same cycle
        st_d.stat = (rd_clr_i ? '0 : st_q.stat) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign stat_o = st_q.stat;
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank #(
    parameter int unsigned NUM_CNT  = 4,
    parameter int unsigned NUM_PORT = 2,
    parameter int unsigned CNT_W    = 12,
    localparam int unsigned STAT_W  = NUM_CNT + 2 * NUM_PORT,
    localparam int unsigned DATA_W  = (STAT_W > CNT_W) ? STAT_W : CNT_W,
    localparam int unsigned ADDR_W  = $clog2(ecb_pkg::ADDR_CNT0 + NUM_CNT)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_CNT-1:0]  cnt_inc_i,
    input  logic [NUM_PORT-1:0] rx_evt_i,
    input  logic [NUM_PORT-1:0] tx_evt_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [STAT_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                irq_o
);
    import ecb_pkg::*;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CNT-1:0]            cnt_hit;
    logic [NUM_CNT-1:0]            cnt_clr;
    logic [NUM_CNT-1:0]            ovf;
    logic [CNT_W-1:0]              cnt_sel;
    logic [STAT_W-1:0]             en_q;
    logic [STAT_W-1:0]             stat_q;
    logic [STAT_W-1:0]             set_vec;
    rsel_e                         rsel;
    logic                          en_we;
    logic                          rd_clr;

    // Address decode
    always_comb begin
        rsel    = SEL_NONE;
        cnt_hit = '0;
        cnt_sel = '0;
        if (addr_i == ADDR_W'(ADDR_EN))   rsel = SEL_EN;
        if (addr_i == ADDR_W'(ADDR_STAT)) rsel = SEL_STAT;
        for (int k = 0; k < int'(NUM_CNT); k++) begin
            if (addr_i == ADDR_W'(ADDR_CNT0 + k)) begin
                rsel       = SEL_CNT;
                cnt_hit[k] = 1'b1;
                cnt_sel    = cnt_all[k];
            end
        end
    end

    assign cnt_clr = cnt_hit & {NUM_CNT{wr_i}};
    assign en_we   = wr_i && (rsel == SEL_EN);
    assign rd_clr  = rd_i && (rsel == SEL_STAT);
    assign set_vec = {tx_evt_i, rx_evt_i, ovf};

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        ecb_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .inc_i    (cnt_inc_i[k]),
            .clr_i    (cnt_clr[k]),
            .wrap_en_i(en_q[k]),
            .cnt_o    (cnt_all[k]),
            .ovf_o    (ovf[k])
        );
    end

    ecb_status #(
        .STAT_W(STAT_W)
    ) u_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_we_i   (en_we),
        .en_wdata_i(wdata_i),
        .rd_clr_i  (rd_clr),
        .set_i     (set_vec),
        .en_o      (en_q),
        .stat_o    (stat_q)
    );

    // Read data mux
    always_comb begin
        unique case (rsel)
            SEL_EN:   rdata_o = DATA_W'(en_q);
            SEL_STAT: rdata_o = DATA_W'(stat_q);
            SEL_CNT:  rdata_o = DATA_W'(cnt_sel);
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = |(stat_q & en_q);
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk #(
    parameter int unsigned NUM_CNT  = 4,
    parameter int unsigned NUM_PORT = 2,
    parameter int unsigned CNT_W    = 12,
    localparam int unsigned STAT_W  = NUM_CNT + 2 * NUM_PORT,
    localparam int unsigned ADDR_W  = $clog2(ecb_pkg::ADDR_CNT0 + NUM_CNT)
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [NUM_CNT-1:0]            cnt_inc_i,
    input logic [NUM_PORT-1:0]           rx_evt_i,
    input logic [NUM_PORT-1:0]           tx_evt_i,
    input logic                          wr_i,
    input logic                          rd_i,
    input logic [ADDR_W-1:0]             addr_i,
    input logic                          irq_o,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
    input logic [STAT_W-1:0]             en_q,
    input logic [STAT_W-1:0]             stat_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic rd_stat;
    assign rd_stat = rd_i && (addr_i == ADDR_W'(ecb_pkg::ADDR_STAT));

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt_chk
        logic wr_k;
        assign wr_k = wr_i && (addr_i == ADDR_W'(ecb_pkg::ADDR_CNT0 + k));

        p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_inc_i[k] && !wr_k && cnt_all[k] != CNT_MAX
            |=> cnt_all[k] == $past(cnt_all[k]) + 1'b1);

        p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_q[k] && cnt_all[k] == CNT_MAX && !wr_k
            |=> cnt_all[k] == CNT_MAX);

        p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_q[k] && cnt_all[k] == CNT_MAX && cnt_inc_i[k] && !wr_k
            |=> cnt_all[k] == '0 && stat_q[k]);

        p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_k |=> cnt_all[k] == '0);
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port_chk
        p_keep_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rd_stat && rx_evt_i[p] |=> stat_q[NUM_CNT + p]);

        p_keep_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rd_stat && tx_evt_i[p] |=> stat_q[NUM_CNT + NUM_PORT + p]);
    end

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stat && rx_evt_i == '0 && tx_evt_i == '0 && cnt_inc_i == '0
        |=> stat_q == '0);

    p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (stat_q & en_q) != '0);
endmodule

bind ecb_bank ecb_bank_chk #(
    .NUM_CNT (NUM_CNT),
    .NUM_PORT(NUM_PORT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_inc_i(cnt_inc_i),
    .rx_evt_i (rx_evt_i),
    .tx_evt_i (tx_evt_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .irq_o    (irq_o),
    .cnt_all  (cnt_all),
    .en_q     (en_q),
    .stat_q   (stat_q)
);

// File: tb/test_ecb_bank.sv
module test_ecb_bank;
    localparam int NUM_CNT  = 4;
    localparam int NUM_PORT = 2;
    localparam int CNT_W    = 12;
    localparam int STAT_W   = NUM_CNT + 2 * NUM_PORT;
    localparam int DATA_W   = 12;
    localparam int ADDR_W   = 3;

    logic                clk_i = 1'b0;
    logic                rst_ni = 1'b0;
    logic [NUM_CNT-1:0]  cnt_inc_i = '0;
    logic [NUM_PORT-1:0] rx_evt_i = '0;
    logic [NUM_PORT-1:0] tx_evt_i = '0;
    logic                wr_i = 1'b0;
    logic                rd_i = 1'b0;
    logic [ADDR_W-1:0]   addr_i = '0;
    logic [STAT_W-1:0]   wdata_i = '0;
    logic [DATA_W-1:0]   rdata_o;
    logic                irq_o;

    ecb_bank #(
        .NUM_CNT (NUM_CNT),
        .NUM_PORT(NUM_PORT),
        .CNT_W   (CNT_W)
    ) i_ecb_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cnt_inc_i(cnt_inc_i),
        .rx_evt_i (rx_evt_i),
        .tx_evt_i (tx_evt_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );

    always #5 clk_i = ~clk_i;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [11:0] exp_q[$];
    string       tag_q[$];

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic cyc();
        @(posedge clk_i);
        #1;
    endtask

    // Driver: queue the expected read value, then issue the strobe
    task automatic rd(input int a, input logic [11:0] e, input string tag);
        addr_i = ADDR_W'(a);
        rd_i   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cyc();
        rd_i = 1'b0;
    endtask

    task automatic wr(input int a, input logic [STAT_W-1:0] d);
        addr_i  = ADDR_W'(a);
        wdata_i = d;
        wr_i    = 1'b1;
        cyc();
        wr_i = 1'b0;
    endtask

    task automatic pulse(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            cnt_inc_i[k] = 1'b1;
            cyc();
        end
        cnt_inc_i[k] = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk_i);
        n_cmp++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, e);
        end
        @(posedge clk_i);
        #1;
    endtask

    // Monitor: compare each read against the scoreboard head
    always @(negedge clk_i) begin
        if (rd_i && rst_ni) begin
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", rdata_o);
            end else begin
                logic [11:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (rdata_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata_o, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        rst_ni = 1'b1;
        cyc();

        // R1: reset state
        rd(0, 12'h000, "R1 enable word");
        rd(1, 12'h000, "R1 status word");
        rd(2, 12'h000, "R1 counter0");
        check_irq(1'b0, "R1 irq");

        // R2: independent increments
        pulse(0, 3);
        pulse(1, 1);
        rd(2, 12'h003, "R2 counter0");
        rd(3, 12'h001, "R2 counter1");
        rd(5, 12'h000, "R2 counter3 untouched");
        rd(2, 12'h003, "R9 counter read keeps value");

        // R3: disabled counter saturates
        pulse(1, 4094);
        rd(3, 12'hFFF, "R3 counter1 at max");
        pulse(1, 5);
        rd(3, 12'hFFF, "R3 counter1 holds");
        rd(1, 12'h000, "R3 no overflow flag");

        // R4: enabled counter wraps
        wr(0, 8'h01);
        rd(0, 12'h001, "R10 enable readback");
        pulse(0, 4092);
        rd(2, 12'hFFF, "R4 counter0 at max");
        pulse(0, 1);
        rd(2, 12'h000, "R4 counter0 wrapped");
        check_irq(1'b1, "R8 irq on enabled overflow");
        pulse(0, 2);
        rd(2, 12'h002, "R4 counting continues");
        rd(1, 12'h001, "R6 status shows overflow");
        rd(1, 12'h000, "R6 status cleared by read");
        check_irq(1'b0, "R8 irq drops after clear");

        // R9: counter clear, including clear against increment
        wr(3, 8'h00);
        rd(3, 12'h000, "R9 counter1 cleared");
        pulse(2, 2);
        rd(4, 12'h002, "R2 counter2");
        cnt_inc_i[2] = 1'b1;
        wr(4, 8'h00);
        cnt_inc_i[2] = 1'b0;
        rd(4, 12'h000, "R9 clear beats increment");

        // R5 and R8: event flags and masking
        rx_evt_i[1] = 1'b1;
        cyc();
        rx_evt_i[1] = 1'b0;
        check_irq(1'b0, "R8 masked event keeps irq low");
        wr(0, 8'h21);
        check_irq(1'b1, "R8 irq once enabled");
        rd(1, 12'h020, "R5 rx port1 flag at bit 5");
        tx_evt_i[0] = 1'b1;
        cyc();
        tx_evt_i[0] = 1'b0;
        rd(1, 12'h040, "R5 tx port0 flag at bit 6");

        // R7: event during a status read survives
        tx_evt_i[1] = 1'b1;
        rd(1, 12'h000, "R7 read during event");
        tx_evt_i[1] = 1'b0;
        rd(1, 12'h080, "R7 event kept after read");

        // R10: status not writable, unmapped reads zero
        rx_evt_i[0] = 1'b1;
        cyc();
        rx_evt_i[0] = 1'b0;
        wr(1, 8'hFF);
        rd(1, 12'h010, "R10 status write ignored");
        rd(0, 12'h021, "R10 enable unchanged");
        rd(6, 12'h000, "R10 unmapped address 6");
        rd(7, 12'h000, "R10 unmapped address 7");

        cyc();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d reads not seen, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule